// File: doc/BRIEF.md
# Test Access Port Controller

This block is the serial test port of a device. A sixteen-state controller advances on the rising edge of the test clock under the control of the mode-select line alone. It loads a 10-bit instruction from the serial input and decodes the active instruction into a data-path choice and pin-control flags. It holds a one-bit pass-through register and a shared 32-bit register that captures either the identification word or a user word.

The serial output changes on the falling edge of the test clock. It is driven only while an instruction or data register is shifting, and it reads from whichever register the active instruction selects. The block does not contain the boundary-cell chain or the user data registers. It drives them instead: it gives state strobes, path selects, a test-mode flag and a float-all-outputs flag, and it takes back their serial outputs.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the sixteen-state test-port graph on each rising test-clock edge, steered only by the mode-select line. The outputs `dr_capture`, `dr_shift` and `dr_update` are high exactly while the controller is in the data-register capture, shift and update states.
- R2: Five consecutive rising edges with mode-select high reach the reset state from any state. `rst_n` sampled low on a rising edge also forces the reset state. Entering the reset state makes IDCODE (0x006) the active instruction.
- R3: From the reset state, the mode-select sequence 0,1,1,0,0 reaches the instruction shift state. Instruction capture loads 0x001, so the first two bits shifted out are 1 and then 0.
- R4: Bits are shifted into the instruction register least-significant bit first. Instruction update makes the shifted word active. The opcode map is: SAMPLE/PRELOAD 0x005, EXTEST 0x00F, BYPASS 0x3FF, USERCODE 0x007, IDCODE 0x006, HIGHZ 0x00B, CLAMP 0x00A, USER0 0x00C, USER1 0x00E. Any other value acts as BYPASS.
- R5: BYPASS, CLAMP, HIGHZ and unmapped opcodes select the one-bit register. It captures 0 and delays the serial input by exactly one shift.
- R6: IDCODE captures the word {version[3:0], part[15:0], manufacturer[10:0], 1}, which is shifted out least-significant bit first.
- R7: USERCODE captures the 32-bit user word into the same register, which is shifted out least-significant bit first.
- R8: SAMPLE/PRELOAD and EXTEST raise `sel_bsr` and route `bsr_so` to the serial output. USER0 and USER1 raise `sel_usr0` and `sel_usr1` respectively, and both route `usr_so` to the serial output.
- R9: `bs_mode` is high for EXTEST, CLAMP and HIGHZ only. `bs_hiz` is high for HIGHZ only.
- R10: `tdo` and `tdo_en` change only on falling test-clock edges. `tdo_en` is high only in the two shift states, and `tdo` is 0 while `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial return from the boundary-cell chain |
| usr_so | input | 1 | Serial return from the selected user register |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for `tdo` |
| dr_capture | output | 1 | Data-register capture state strobe |
| dr_shift | output | 1 | Data-register shift state strobe |
| dr_update | output | 1 | Data-register update state strobe |
| sel_bsr | output | 1 | Boundary-cell chain selected |
| sel_usr0 | output | 1 | First user register selected |
| sel_usr1 | output | 1 | Second user register selected |
| bs_mode | output | 1 | Boundary cells drive update values to the pins |
| bs_hiz | output | 1 | Force every pin output enable inactive |

## Verification
A weighted random mode-select walk with random serial input runs against an independent model of the graph and the instruction register. This walk separates wrong transitions, mistimed strobes and instruction-update errors from the data-path checks. Reads of the 32-bit register with all-zero input tell the identification word apart from the user word. Random patterns pushed through the one-bit path show a missing or extra delay. Holding `bsr_so` at 1 and `usr_so` at 0, and then the reverse, separates the external routes from the one-bit register, which always leads with a 0. A probe taken between the rising and the falling edge shows whether `tdo` moves on the wrong edge.

// File: rtl/scan_tap_pkg.sv
// Shared types for the test access port: controller states, opcode map,
// data-path choices and the next-state function of the controller graph.
package scan_tap_pkg;

    localparam int IR_W  = 10;
    localparam int ID_W  = 32;

    localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
    localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
    localparam logic [IR_W-1:0] OP_BYPASS   = 10'h3FF;
    localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
    localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
    localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
    localparam logic [IR_W-1:0] OP_USER0    = 10'h00C;
    localparam logic [IR_W-1:0] OP_USER1    = 10'h00E;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 10'h001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1,
        ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1,
        ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP, PATH_ID, PATH_BSR, PATH_USR
    } path_e;

    // Next state of the controller for a given mode-select value.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:    return m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     return m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   return m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: return m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: return m ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: return m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   return m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: return m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: return m ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: return m ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     return m ? ST_DR_SEL   : ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test port controller.
// Assumes: rst_n is synchronous to tck; tms is stable around the rising edge.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e nxt
);

    // Next state from the graph, or the reset state while rst_n is low.
    always_comb begin
        nxt = rst_n ? tap_next(state, tms) : ST_RESET;
    end

    // State register.
    always_ff @(posedge tck) begin
        state <= nxt;
    end

    // Run length of consecutive high mode-select edges, saturating at five (checker use).
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (!rst_n || !tms) ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    // R2: five high mode-select edges always land in reset.
    a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    // R1: capture with mode-select low moves on into shift.
    a_r1_capture_to_shift: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DR_CAP && !tms) |=> (state == ST_DR_SHIFT));

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction shift register, active instruction and decoder.
// Assumes: state/nxt come from the controller in the same clock domain.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  tap_state_e nxt,
    input  logic       tdi,
    output logic       ir_lsb,
    output path_e      path,
    output logic       use_user,
    output logic       usr_hi,
    output logic       mode,
    output logic       hiz
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_act;

    // Shift stage: capture the fixed pattern, then shift toward the LSB.
    always_ff @(posedge tck) begin
        if (state == ST_IR_CAP)        ir_sr <= IR_CAPTURE;
        else if (state == ST_IR_SHIFT) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: IDCODE on reset entry, shifted word on update.
    always_ff @(posedge tck) begin
        if (!rst_n || nxt == ST_RESET) ir_act <= OP_IDCODE;
        else if (state == ST_IR_UPD)   ir_act <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    // Decode the active instruction into path and pin-control flags.
    always_comb begin
        path     = PATH_BYP;
        use_user = 1'b0;
        usr_hi   = 1'b0;
        mode     = 1'b0;
        hiz      = 1'b0;
        case (ir_act)
            OP_SAMPLE:   path = PATH_BSR;
            OP_EXTEST:   begin path = PATH_BSR; mode = 1'b1; end
            OP_IDCODE:   path = PATH_ID;
            OP_USERCODE: begin path = PATH_ID; use_user = 1'b1; end
            OP_HIGHZ:    begin mode = 1'b1; hiz = 1'b1; end
            OP_CLAMP:    mode = 1'b1;
            OP_USER0:    path = PATH_USR;
            OP_USER1:    begin path = PATH_USR; usr_hi = 1'b1; end
            OP_BYPASS:   path = PATH_BYP;
            default:     path = PATH_BYP;
        endcase
    end

    // R3: capture leaves the fixed pattern in the shift stage.
    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IR_CAP) |=> (ir_sr == IR_CAPTURE));

    // R4: update copies the shifted word into the active instruction.
    a_r4_update_loads: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IR_UPD) |=> (ir_act == $past(ir_sr)));

endmodule

// File: rtl/scan_tap_dr.sv
// Internal data registers: one-bit pass-through and shared 32-bit word register
// that captures either the identification word or the user word.
// Assumes: path/use_user are stable throughout a data-register scan.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_WORD   = 32'h0000_0001,
    parameter logic [ID_W-1:0] USER_WORD = 32'h0000_0000
) (
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  logic       tdi,
    input  path_e      path,
    input  logic       use_user,
    output logic       byp_q,
    output logic       id_lsb
);

    logic [ID_W-1:0] id_sr;

    // One-bit register: captures 0, follows tdi while shifting.
    always_ff @(posedge tck) begin
        if (path == PATH_BYP) begin
            if (state == ST_DR_CAP)        byp_q <= 1'b0;
            else if (state == ST_DR_SHIFT) byp_q <= tdi;
        end
    end

    // Word register: captures identification or user word, shifts toward the LSB.
    always_ff @(posedge tck) begin
        if (path == PATH_ID) begin
            if (state == ST_DR_CAP)        id_sr <= use_user ? USER_WORD : ID_WORD;
            else if (state == ST_DR_SHIFT) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    assign id_lsb = id_sr[0];

    // R5: while selected and shifting, the one-bit register takes the serial input.
    a_r5_bypass_follows: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DR_SHIFT && path == PATH_BYP) |=> (byp_q == $past(tdi)));

    // R6: identification capture loads the fixed word.
    a_r6_id_capture: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DR_CAP && path == PATH_ID && !use_user) |=> (id_sr == ID_WORD));

endmodule

// File: rtl/scan_tap.sv
// Test access port top: controller, instruction stage, internal data registers,
// and the falling-edge serial output stage with its enable.
// Assumes: external chains present bsr_so/usr_so stable around the falling edge.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h3181,
    parameter logic [10:0] ID_MFR     = 11'h06E,
    parameter logic [31:0] USER_WORD  = 32'h5A3C_9617
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_so,
    input  logic usr_so,
    output logic tdo,
    output logic tdo_en,
    output logic dr_capture,
    output logic dr_shift,
    output logic dr_update,
    output logic sel_bsr,
    output logic sel_usr0,
    output logic sel_usr1,
    output logic bs_mode,
    output logic bs_hiz
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

    tap_state_e state, nxt;
    path_e      path;
    logic       ir_lsb, use_user, usr_hi, byp_q, id_lsb;
    logic       shifting, out_bit;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state),
        .nxt   (nxt)
    );

    scan_tap_ir u_ir (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (state),
        .nxt      (nxt),
        .tdi      (tdi),
        .ir_lsb   (ir_lsb),
        .path     (path),
        .use_user (use_user),
        .usr_hi   (usr_hi),
        .mode     (bs_mode),
        .hiz      (bs_hiz)
    );

    scan_tap_dr #(
        .ID_WORD   (ID_WORD),
        .USER_WORD (USER_WORD)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (state),
        .tdi      (tdi),
        .path     (path),
        .use_user (use_user),
        .byp_q    (byp_q),
        .id_lsb   (id_lsb)
    );

    // State strobes and selects for the external registers.
    assign dr_capture = (state == ST_DR_CAP);
    assign dr_shift   = (state == ST_DR_SHIFT);
    assign dr_update  = (state == ST_DR_UPD);
    assign sel_bsr    = (path == PATH_BSR);
    assign sel_usr0   = (path == PATH_USR) && !usr_hi;
    assign sel_usr1   = (path == PATH_USR) && usr_hi;

    // Pick the bit that the serial output presents next.
    always_comb begin
        shifting = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
        if (state == ST_IR_SHIFT) out_bit = ir_lsb;
        else begin
            case (path)
                PATH_ID:  out_bit = id_lsb;
                PATH_BSR: out_bit = bsr_so;
                PATH_USR: out_bit = usr_so;
                default:  out_bit = byp_q;
            endcase
        end
    end

    // Falling-edge output stage: data and enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting & out_bit;
            tdo_en <= shifting;
        end
    end

    // R10: enable is up exactly in the shift states once the half cycle settles.
    a_r10_enable_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == ((state == ST_IR_SHIFT) || (state == ST_DR_SHIFT)));

    // R10: a disabled output stays low.
    a_r10_quiet_when_off: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);

endmodule

// File: tb/scan_tap_tb.sv
// Self-checking bench: directed scans plus a seeded random mode-select walk
// against an independent controller and instruction model.
module scan_tap_tb;

    localparam logic [3:0]  T_VER  = 4'h0;
    localparam logic [15:0] T_PART = 16'h3181;
    localparam logic [10:0] T_MFR  = 11'h06E;
    localparam logic [31:0] T_USER = 32'h5A3C_9617;

    logic tck = 1'b0;
    logic rst_n, tms, tdi, bsr_so, usr_so;
    logic tdo, tdo_en, dr_capture, dr_shift, dr_update;
    logic sel_bsr, sel_usr0, sel_usr1, bs_mode, bs_hiz;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4ns tck = ~tck;

    scan_tap #(
        .ID_VERSION (T_VER),
        .ID_PART    (T_PART),
        .ID_MFR     (T_MFR),
        .USER_WORD  (T_USER)
    ) u_dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
        .bsr_so(bsr_so), .usr_so(usr_so),
        .tdo(tdo), .tdo_en(tdo_en),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .sel_bsr(sel_bsr), .sel_usr0(sel_usr0), .sel_usr1(sel_usr1),
        .bs_mode(bs_mode), .bs_hiz(bs_hiz)
    );

    // Model: state numbering is the bench's own.
    int         m_st  = 0;
    logic [9:0] m_sr  = '0;
    logic [9:0] m_act = 10'h006;

    function automatic int nx(input int s, input logic m);
        case (s)
            0: return m ? 0 : 1;   1: return m ? 2 : 1;
            2: return m ? 9 : 3;   3: return m ? 5 : 4;
            4: return m ? 5 : 4;   5: return m ? 8 : 6;
            6: return m ? 7 : 6;   7: return m ? 8 : 4;
            8: return m ? 2 : 1;   9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    // {sel_bsr, sel_usr0, sel_usr1, mode, hiz} expected for an opcode.
    function automatic logic [4:0] dec(input logic [9:0] op);
        case (op)
            10'h005: return 5'b10000;
            10'h00F: return 5'b10010;
            10'h00C: return 5'b01000;
            10'h00E: return 5'b00100;
            10'h00A: return 5'b00010;
            10'h00B: return 5'b00011;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [31:0] id_word();
        return {T_VER, T_PART, T_MFR, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One test-clock cycle; inputs set after a falling edge, outputs read after the next.
    task automatic step(input logic m, input logic d);
        int ns;
        tms = m; tdi = d;
        @(posedge tck);
        if (m_st == 10) m_sr = 10'h001;
        else if (m_st == 11) m_sr = {d, m_sr[9:1]};
        if (m_st == 15) m_act = m_sr;
        ns = rst_n ? nx(m_st, m) : 0;
        if (ns == 0) m_act = 10'h006;
        m_st = ns;
        @(negedge tck);
        #1ns;
    endtask

    task automatic scan(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
    endtask

    task automatic load_ir(input logic [9:0] op);
        logic [63:0] o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_en === 1'b1, "R3 shift-IR reached", tdo_en, 1);
        scan(10, {54'd0, op}, o);
        chk(o[9:0] === 10'h001, "R3 IR capture pattern", o[9:0], 10'h001);
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        step(1, 0); step(0, 0); step(0, 0);
        scan(n, din, dout);
        step(1, 0); step(0, 0);
    endtask

    task automatic chk_flags(input string tag);
        logic [4:0] e = dec(m_act);
        logic [4:0] a = {sel_bsr, sel_usr0, sel_usr1, bs_mode, bs_hiz};
        chk(a === e, tag, a, e);
    endtask

    // Per-cycle comparison of strobes, enable and decode against the model.
    task automatic chk_walk();
        logic [3:0] e = {m_st == 3, m_st == 4, m_st == 8, (m_st == 4) || (m_st == 11)};
        logic [3:0] a = {dr_capture, dr_shift, dr_update, tdo_en};
        chk(a === e, "R1/R10 walk strobes", a, e);
        chk_flags("R4/R9 walk decode");
        if (!tdo_en) chk(tdo === 1'b0, "R10 disabled tdo low", tdo, 0);
    endtask

    initial begin
        logic [63:0] o, d;
        void'($urandom(32'd20240611));
        rst_n = 0; tms = 1; tdi = 0; bsr_so = 1; usr_so = 0;
        step(1, 0); step(1, 0); step(1, 0);
        rst_n = 1;
        // R2: reset state.
        chk({tdo_en, dr_capture, dr_shift, dr_update} === 4'b0, "R2 reset outputs", {tdo_en, dr_capture, dr_shift, dr_update}, 0);
        chk_flags("R2 reset instruction IDCODE");
        step(0, 0);
        // R6: identification word right after reset.
        scan_dr(32, 64'd0, o);
        chk(o[31:0] === id_word(), "R6 IDCODE after reset", o[31:0], id_word());
        // R7: user word.
        load_ir(10'h007);
        scan_dr(32, 64'd0, o);
        chk(o[31:0] === T_USER, "R7 USERCODE word", o[31:0], T_USER);
        // R6: IDCODE loaded explicitly.
        load_ir(10'h006);
        scan_dr(32, 64'hFFFF_FFFF, o);
        chk(o[31:0] === id_word(), "R6 IDCODE loaded", o[31:0], id_word());
        // R5: one-cycle delay with random patterns, BYPASS and an unmapped opcode.
        load_ir(10'h3FF);
        chk_flags("R4 BYPASS decode");
        for (int k = 0; k < 4; k++) begin
            d = {$urandom, $urandom};
            scan_dr(20, d, o);
            chk(o[19:0] === {d[18:0], 1'b0}, "R5 bypass delay", o[19:0], {d[18:0], 1'b0});
        end
        load_ir(10'h155);
        chk_flags("R4 unmapped decode");
        d = 64'hA5C3;
        scan_dr(16, d, o);
        chk(o[15:0] === {d[14:0], 1'b0}, "R4 unmapped acts as bypass", o[15:0], {d[14:0], 1'b0});
        // R8/R9: boundary paths.
        load_ir(10'h00F);
        chk_flags("R9 EXTEST flags");
        scan_dr(12, 64'd0, o);
        chk(o[11:0] === 12'hFFF, "R8 EXTEST reads bsr_so", o[11:0], 12'hFFF);
        load_ir(10'h005);
        chk_flags("R9 SAMPLE flags");
        bsr_so = 0; usr_so = 1;
        scan_dr(12, 64'hFFF, o);
        chk(o[11:0] === 12'h000, "R8 SAMPLE reads bsr_so", o[11:0], 0);
        load_ir(10'h00C);
        chk_flags("R8 USER0 select");
        scan_dr(12, 64'd0, o);
        chk(o[11:0] === 12'hFFF, "R8 USER0 reads usr_so", o[11:0], 12'hFFF);
        load_ir(10'h00E);
        chk_flags("R8 USER1 select");
        scan_dr(12, 64'd0, o);
        chk(o[11:0] === 12'hFFF, "R8 USER1 reads usr_so", o[11:0], 12'hFFF);
        // R9/R5: CLAMP and HIGHZ keep the one-bit path.
        load_ir(10'h00A);
        chk_flags("R9 CLAMP flags");
        scan_dr(8, 64'hB6, o);
        chk(o[7:0] === 8'h6C, "R5 CLAMP one-bit path", o[7:0], 8'h6C);
        load_ir(10'h00B);
        chk_flags("R9 HIGHZ flags");
        scan_dr(8, 64'h5A, o);
        chk(o[7:0] === 8'hB4, "R5 HIGHZ one-bit path", o[7:0], 8'hB4);
        // R10: output moves on the falling edge only.
        load_ir(10'h3FF);
        step(1, 0); step(0, 0); step(0, 0);
        chk(tdo === 1'b0, "R10 bypass capture out", tdo, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1ns;
        chk(tdo === 1'b0, "R10 no change at rising edge", tdo, 0);
        @(negedge tck); #1ns;
        chk(tdo === 1'b1, "R10 change at falling edge", tdo, 1);
        step(1, 0); step(1, 0); step(0, 0);
        // R2: five high edges return to reset and restore IDCODE.
        for (int i = 0; i < 5; i++) step(1, 0);
        chk_flags("R2 five-ones IDCODE");
        // R1/R2/R4/R9/R10: random walk against the model.
        for (int n = 0; n < 3000; n++) begin
            if (n == 1500) rst_n = 0;
            step(($urandom % 100) < 40, $urandom % 2);
            rst_n = 1;
            chk_walk();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1200us;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule